// File: doc/BRIEF.md
# Flash Controller Register Block

This block is the software-visible face of an on-chip flash controller. A simple word-oriented bus port reads and writes three registers. The first holds the low-power mode and can only be written when a 16-bit unlock key is supplied. The second reports whether an operation is in progress and whether a program attempt failed. The third launches program, erase or checksum operations. Launched operations go to the flash macro through a one-cycle start pulse, an operation code and a latched target word address. The macro answers with a done strobe and an error flag.

Before a program or erase is issued, the block screens the request. A target word address at or beyond the flash size rejects the operation. For a program, the macro's current content of the target word (presented on `fm_old_word`) must be fully erased; otherwise the program is rejected. A rejected operation never reaches the macro. It leaves the busy flag low and raises the program-error flag on the next clock edge.

Top module: `fctl_regs`

## Requirements
- R1: After reset every register reads zero and `fm_start` is low.
- R2: A write to offset 0x0 whose bits 31:16 equal 0x5AFA stores bits 1:0 as the low-power mode (00 off, 10 slow power-saving, 01 and 11 reserved but stored). A read returns the mode in bits 1:0 and zero in bits 31:2, so the key never reads back.
- R3: A write to offset 0x0 with any other key value leaves the low-power mode unchanged.
- R4: Writing 1 to control bit 5 (program) while idle launches a program when the target is legal and erased. In the cycle after the write edge, busy (status bit 0) is 1, `fm_start` is 1, `fm_op` is 01 and `fm_addr` holds the target word address.
- R5: `fm_start` lasts exactly one cycle. The launched start bit (5 for program, 6 for erase) reads 1 only in that cycle and 0 afterwards.
- R6: `fm_done` while busy clears busy on the same clock edge. If `fm_err` is high with it, status bit 2 (program error) is set.
- R7: A program or erase whose target word address is at or above `FLASH_WORDS` is rejected. No start pulse is issued, busy stays 0, and status bit 2 reads 1 after the write edge.
- R8: A program whose `fm_old_word` is not 0xFFFFFFFF at the write is rejected in the same way. An erase does not check the old word.
- R9: Writing 1 to control bit 7 launches a checksum operation (`fm_op` 11). Bit 7 stays 1 while busy and clears on the edge where busy falls.
- R10: Writes to the control register while busy is 1 are ignored: no new start pulse and no change to the control bits.
- R11: Writing status with bit 2 = 0 clears the program error. Writing 1 there has no effect. A hardware set in the same cycle as a clearing write wins.
- R12: When several of control bits 7, 6, 5 are written together, only one operation launches, with priority checksum over erase over program.
- R13: Offset 0xC and all bits that are not listed read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | BUS_AW | Byte offset of the register; bits 3:2 select it |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tgt_waddr | input | ADDR_W | Target flash word address for the next operation |
| fm_old_word | input | 32 | Current macro content of the word at `tgt_waddr` |
| fm_start | output | 1 | One-cycle operation start toward the macro |
| fm_op | output | 2 | Operation code: 01 program, 10 erase, 11 checksum |
| fm_addr | output | ADDR_W | Target word address latched at launch |
| fm_done | input | 1 | Operation finished strobe from the macro |
| fm_err | input | 1 | Macro failure flag, valid with `fm_done` |

## Verification
On every cycle, the bound checker enforces that a start pulse is single and only appears while busy. It also checks that a rejected request produces no pulse and leaves the error flag raised, and that the error flag only falls on a clearing write. Further cycle-level checks cover the checksum bit dropping with busy, locked low-power writes, and control writes during busy. Only the bench scenarios can show the exact values: the operation code chosen under priority, the address boundary at `FLASH_WORDS`, the old-word screening that applies to program and not erase, and the set-wins collision between a macro error and a clearing write.

// File: rtl/fctl_pkg.sv
package fctl_pkg;

  localparam logic [15:0] LP_UNLOCK   = 16'h5AFA;
  localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;

  localparam logic [1:0] SLOT_LP   = 2'd0;
  localparam logic [1:0] SLOT_STAT = 2'd1;
  localparam logic [1:0] SLOT_CTRL = 2'd2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_CSUM  = 2'b11
  } fop_e;

  function automatic fop_e pick_op(input logic want_csum,
                                   input logic want_erase,
                                   input logic want_prog);
    if (want_csum)  return OP_CSUM;
    if (want_erase) return OP_ERASE;
    if (want_prog)  return OP_PROG;
    return OP_NONE;
  endfunction

  function automatic logic key_ok(input logic [15:0] key);
    return key == LP_UNLOCK;
  endfunction

  function automatic logic word_erased(input logic [31:0] w);
    return w == ERASED_WORD;
  endfunction

  function automatic logic [31:0] pack_lp(input logic [1:0] mode);
    return {30'd0, mode};
  endfunction

  function automatic logic [31:0] pack_stat(input logic perr, input logic busy);
    return {29'd0, perr, 1'b0, busy};
  endfunction

  function automatic logic [31:0] pack_ctrl(input logic csum, input logic erase,
                                            input logic prog);
    return {24'd0, csum, erase, prog, 5'd0};
  endfunction

endpackage

// File: rtl/fctl_lpctl.sv
module fctl_lpctl
  import fctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] key,
  input  logic [1:0]  mode_in,
  output logic [1:0]  mode,
  output logic        ev_unlock
);

  assign ev_unlock = wr && key_ok(key);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode <= 2'b00;
    else if (ev_unlock) mode <= mode_in;
  end

endmodule

// File: rtl/fctl_errflag.sv
module fctl_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_wr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_wr)  flag <= 1'b0;
  end

endmodule

// File: rtl/fctl_opctl.sv
module fctl_opctl
  import fctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int FLASH_WORDS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              req_csum,
  input  logic              req_erase,
  input  logic              req_prog,
  input  logic [ADDR_W-1:0] tgt_waddr,
  input  logic [31:0]       old_word,
  input  logic              fm_done,
  input  logic              fm_err,
  output logic              busy,
  output logic              csum_sel,
  output logic              erase_bit,
  output logic              prog_bit,
  output logic              start_pulse,
  output logic [1:0]        op_code,
  output logic [ADDR_W-1:0] op_addr,
  output logic              ev_launch,
  output logic              ev_reject,
  output logic              ev_finish,
  output logic              ev_done_err
);

  localparam logic [ADDR_W:0] LIMIT = FLASH_WORDS[ADDR_W:0];

  fop_e op_sel;
  fop_e op_q;
  logic accept;
  logic needs_addr;
  logic addr_bad;
  logic data_bad;

  assign accept     = ctrl_wr && !busy;
  assign op_sel     = pick_op(req_csum, req_erase, req_prog);
  assign needs_addr = (op_sel == OP_PROG) || (op_sel == OP_ERASE);
  assign addr_bad   = needs_addr && !({1'b0, tgt_waddr} < LIMIT);
  assign data_bad   = (op_sel == OP_PROG) && !word_erased(old_word);

  assign ev_launch   = accept && (op_sel != OP_NONE) && !addr_bad && !data_bad;
  assign ev_reject   = accept && (op_sel != OP_NONE) && (addr_bad || data_bad);
  assign ev_finish   = busy && fm_done;
  assign ev_done_err = ev_finish && fm_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      csum_sel    <= 1'b0;
      erase_bit   <= 1'b0;
      prog_bit    <= 1'b0;
      start_pulse <= 1'b0;
      op_q        <= OP_NONE;
      op_addr     <= '0;
    end else begin
      start_pulse <= ev_launch;
      erase_bit   <= ev_launch && (op_sel == OP_ERASE);
      prog_bit    <= ev_launch && (op_sel == OP_PROG);
      if (ev_launch) begin
        busy     <= 1'b1;
        csum_sel <= (op_sel == OP_CSUM);
        op_q     <= op_sel;
        op_addr  <= tgt_waddr;
      end else if (ev_finish) begin
        busy     <= 1'b0;
        csum_sel <= 1'b0;
      end
    end
  end

  assign op_code = op_q;

endmodule

// File: rtl/fctl_regs.sv
module fctl_regs
  import fctl_pkg::*;
#(
  parameter int BUS_AW      = 4,
  parameter int ADDR_W      = 8,
  parameter int FLASH_WORDS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic [ADDR_W-1:0] tgt_waddr,
  input  logic [31:0]       fm_old_word,
  output logic              fm_start,
  output logic [1:0]        fm_op,
  output logic [ADDR_W-1:0] fm_addr,
  input  logic              fm_done,
  input  logic              fm_err
);

  logic       slot_hi_zero;
  logic [1:0] slot;
  logic       lp_wr;
  logic       stat_wr;
  logic       ctrl_wr;
  logic       stat_clr;
  logic       ev_unlock;
  logic [1:0] lp_mode;
  logic       busy_q;
  logic       csum_q;
  logic       erase_q;
  logic       prog_q;
  logic       perr_q;
  logic       ev_launch;
  logic       ev_reject;
  logic       ev_finish;
  logic       ev_done_err;
  logic       unused_bits;

  if (BUS_AW > 4) begin : g_hi
    assign slot_hi_zero = (bus_addr[BUS_AW-1:4] == '0);
  end else begin : g_nohi
    assign slot_hi_zero = 1'b1;
  end

  assign slot     = bus_addr[3:2];
  assign lp_wr    = bus_we && slot_hi_zero && (slot == SLOT_LP);
  assign stat_wr  = bus_we && slot_hi_zero && (slot == SLOT_STAT);
  assign ctrl_wr  = bus_we && slot_hi_zero && (slot == SLOT_CTRL);
  assign stat_clr = stat_wr && !bus_wdata[2];
  assign unused_bits = ^{bus_wdata[15:8], bus_wdata[4:3], bus_addr[1:0]};

  fctl_lpctl u_lp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (lp_wr),
    .key       (bus_wdata[31:16]),
    .mode_in   (bus_wdata[1:0]),
    .mode      (lp_mode),
    .ev_unlock (ev_unlock)
  );

  fctl_opctl #(
    .ADDR_W      (ADDR_W),
    .FLASH_WORDS (FLASH_WORDS)
  ) u_op (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .req_csum    (bus_wdata[7]),
    .req_erase   (bus_wdata[6]),
    .req_prog    (bus_wdata[5]),
    .tgt_waddr   (tgt_waddr),
    .old_word    (fm_old_word),
    .fm_done     (fm_done),
    .fm_err      (fm_err),
    .busy        (busy_q),
    .csum_sel    (csum_q),
    .erase_bit   (erase_q),
    .prog_bit    (prog_q),
    .start_pulse (fm_start),
    .op_code     (fm_op),
    .op_addr     (fm_addr),
    .ev_launch   (ev_launch),
    .ev_reject   (ev_reject),
    .ev_finish   (ev_finish),
    .ev_done_err (ev_done_err)
  );

  fctl_errflag u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (ev_reject || ev_done_err),
    .clr_wr  (stat_clr),
    .flag    (perr_q)
  );

  always_comb begin
    bus_rdata = 32'd0;
    if (slot_hi_zero) begin
      case (slot)
        SLOT_LP:   bus_rdata = pack_lp(lp_mode);
        SLOT_STAT: bus_rdata = pack_stat(perr_q, busy_q);
        SLOT_CTRL: bus_rdata = pack_ctrl(csum_q, erase_q, prog_q);
        default:   bus_rdata = 32'd0;
      endcase
    end
  end

endmodule

// File: rtl/fctl_regs_chk.sv
module fctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  slot,
  input logic [31:0] bus_rdata,
  input logic        lp_wr,
  input logic        ev_unlock,
  input logic [1:0]  lp_mode,
  input logic        ctrl_wr,
  input logic        stat_clr,
  input logic        busy,
  input logic        csum_sel,
  input logic        fm_start,
  input logic        perr,
  input logic        ev_reject,
  input logic        ev_finish,
  input logic        ev_done_err
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fm_start |=> !fm_start); // R5

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fm_start |-> busy); // R4

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (!fm_start && !busy && perr)); // R7

  AST_CSUM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !csum_sel); // R9

  AST_LP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_wr && !ev_unlock) |=> $stable(lp_mode)); // R3

  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_reject || ev_done_err) |=> perr); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (perr && !stat_clr) |=> perr); // R11

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr && !ev_finish) |=> (busy && $stable(csum_sel) && !fm_start)); // R10

  AST_LP_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 2'd0) |-> (bus_rdata[31:2] == 30'd0)); // R13

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 2'd3) |-> (bus_rdata == 32'd0)); // R13

endmodule

bind fctl_regs fctl_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot        (slot),
  .bus_rdata   (bus_rdata),
  .lp_wr       (lp_wr),
  .ev_unlock   (ev_unlock),
  .lp_mode     (lp_mode),
  .ctrl_wr     (ctrl_wr),
  .stat_clr    (stat_clr),
  .busy        (busy_q),
  .csum_sel    (csum_q),
  .fm_start    (fm_start),
  .perr        (perr_q),
  .ev_reject   (ev_reject),
  .ev_finish   (ev_finish),
  .ev_done_err (ev_done_err)
);

// File: tb/fctl_regs_test.sv
module fctl_regs_test;

  localparam int CLK_PERIOD  = 10;
  localparam int BUS_AW      = 4;
  localparam int ADDR_W      = 8;
  localparam int FLASH_WORDS = 200;
  localparam int WATCHDOG    = 5000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [BUS_AW-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_rdata;
  logic [ADDR_W-1:0] tgt_waddr = '0;
  logic [31:0]       fm_old_word = 32'hFFFF_FFFF;
  logic              fm_start;
  logic [1:0]        fm_op;
  logic [ADDR_W-1:0] fm_addr;
  logic              fm_done = 1'b0;
  logic              fm_err = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fctl_regs #(
    .BUS_AW (BUS_AW), .ADDR_W (ADDR_W), .FLASH_WORDS (FLASH_WORDS)
  ) uut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_we (bus_we), .bus_rdata (bus_rdata), .tgt_waddr (tgt_waddr),
    .fm_old_word (fm_old_word), .fm_start (fm_start), .fm_op (fm_op),
    .fm_addr (fm_addr), .fm_done (fm_done), .fm_err (fm_err)
  );

  localparam logic [3:0] A_LP = 4'h0, A_ST = 4'h4, A_CT = 4'h8, A_HOLE = 4'hC;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    expect_eq(req, v, exp);
  endtask

  task automatic finish_op(input logic err);
    fm_done = 1'b1; fm_err = err;
    tick();
    fm_done = 1'b0; fm_err = 1'b0;
  endtask

  task automatic t_reset();
    expect_reg("R1 lp", A_LP, 32'h0);
    expect_reg("R1 status", A_ST, 32'h0);
    expect_reg("R1 ctrl", A_CT, 32'h0);
    expect_eq("R1 fm_start", {31'd0, fm_start}, 32'h0);
  endtask

  task automatic t_lowpower();
    wr(A_LP, 32'h5AFA_0002);
    expect_reg("R2 slow mode stored, key reads 0", A_LP, 32'h2);
    wr(A_LP, 32'h1234_0000);
    expect_reg("R3 wrong key ignored", A_LP, 32'h2);
    wr(A_LP, 32'h0000_0003);
    expect_reg("R3 zero key ignored", A_LP, 32'h2);
    wr(A_LP, 32'h5AFA_FFFF);
    expect_reg("R2 R13 reserved code stored, upper bits zero", A_LP, 32'h3);
    wr(A_LP, 32'h5AFA_0000);
    expect_reg("R2 disabled", A_LP, 32'h0);
  endtask

  task automatic t_program();
    fm_old_word = 32'hFFFF_FFFF; tgt_waddr = 8'd5;
    wr(A_CT, 32'h0000_0020);
    expect_eq("R4 start pulse", {31'd0, fm_start}, 32'h1);
    expect_eq("R4 op program", {30'd0, fm_op}, 32'h1);
    expect_eq("R4 latched addr", {24'd0, fm_addr}, 32'd5);
    expect_reg("R4 busy", A_ST, 32'h1);
    expect_reg("R5 start bit visible in pulse cycle", A_CT, 32'h20);
    tgt_waddr = 8'd9;
    tick();
    expect_eq("R5 pulse single", {31'd0, fm_start}, 32'h0);
    expect_reg("R5 start bit cleared", A_CT, 32'h0);
    expect_eq("R4 addr held", {24'd0, fm_addr}, 32'd5);
    wr(A_CT, 32'h0000_00C0);
    expect_eq("R10 no start while busy", {31'd0, fm_start}, 32'h0);
    expect_reg("R10 ctrl unchanged", A_CT, 32'h0);
    expect_eq("R10 op unchanged", {30'd0, fm_op}, 32'h1);
    finish_op(1'b0);
    expect_reg("R6 busy cleared, no error", A_ST, 32'h0);
  endtask

  task automatic t_checksum();
    wr(A_CT, 32'h0000_0080);
    expect_eq("R9 checksum start", {31'd0, fm_start}, 32'h1);
    expect_eq("R9 op checksum", {30'd0, fm_op}, 32'h3);
    tick(); tick();
    expect_reg("R9 select held while busy", A_CT, 32'h80);
    expect_reg("R9 busy", A_ST, 32'h1);
    finish_op(1'b0);
    expect_reg("R9 select cleared with busy", A_CT, 32'h0);
    expect_reg("R9 status idle", A_ST, 32'h0);
  endtask

  task automatic t_priority();
    fm_old_word = 32'hFFFF_FFFF; tgt_waddr = 8'd3;
    wr(A_CT, 32'h0000_00E0);
    expect_eq("R12 checksum wins", {30'd0, fm_op}, 32'h3);
    expect_reg("R12 only checksum bit", A_CT, 32'h80);
    finish_op(1'b0);
    wr(A_CT, 32'h0000_0060);
    expect_eq("R12 erase over program", {30'd0, fm_op}, 32'h2);
    expect_reg("R12 only erase bit", A_CT, 32'h40);
    finish_op(1'b0);
  endtask

  task automatic t_bad_address();
    fm_old_word = 32'hFFFF_FFFF; tgt_waddr = 8'(FLASH_WORDS);
    wr(A_CT, 32'h0000_0040);
    expect_eq("R7 no start on illegal erase", {31'd0, fm_start}, 32'h0);
    expect_reg("R7 error set, busy low", A_ST, 32'h4);
    tick();
    expect_eq("R7 still no start", {31'd0, fm_start}, 32'h0);
    wr(A_ST, 32'h0);
    expect_reg("R11 cleared by zero", A_ST, 32'h0);
    tgt_waddr = 8'(FLASH_WORDS - 1);
    wr(A_CT, 32'h0000_0020);
    expect_eq("R7 last legal word launches", {31'd0, fm_start}, 32'h1);
    expect_eq("R7 last legal addr", {24'd0, fm_addr}, 32'(FLASH_WORDS - 1));
    finish_op(1'b0);
  endtask

  task automatic t_old_word();
    tgt_waddr = 8'd7; fm_old_word = 32'h0000_FFFF;
    wr(A_CT, 32'h0000_0020);
    expect_eq("R8 no start on dirty word", {31'd0, fm_start}, 32'h0);
    expect_reg("R8 error set", A_ST, 32'h4);
    wr(A_ST, 32'h0000_0004);
    expect_reg("R11 writing one has no effect", A_ST, 32'h4);
    wr(A_ST, 32'h0);
    expect_reg("R11 cleared", A_ST, 32'h0);
    wr(A_CT, 32'h0000_0040);
    expect_eq("R8 erase ignores old word", {31'd0, fm_start}, 32'h1);
    finish_op(1'b0);
    expect_reg("R8 erase done clean", A_ST, 32'h0);
    fm_old_word = 32'hFFFF_FFFF;
  endtask

  task automatic t_done_error();
    tgt_waddr = 8'd11;
    wr(A_CT, 32'h0000_0020);
    tick();
    bus_addr = A_ST; bus_wdata = 32'h0; bus_we = 1'b1;
    fm_done = 1'b1; fm_err = 1'b1;
    tick();
    bus_we = 1'b0; fm_done = 1'b0; fm_err = 1'b0;
    expect_reg("R6 R11 macro error sets over clearing write", A_ST, 32'h4);
    wr(A_ST, 32'h0);
    expect_reg("R11 clear after collision", A_ST, 32'h0);
  endtask

  task automatic t_holes();
    expect_reg("R13 unmapped offset", A_HOLE, 32'h0);
    expect_reg("R13 idle ctrl", A_CT, 32'h0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_lowpower();
    t_program();
    t_checksum();
    t_priority();
    t_bad_address();
    t_old_word();
    t_done_error();
    t_holes();
    report();
  end

endmodule